// File: doc/BRIEF.md
# Widescreen Signalling Word Generator

This block builds the 20-bit widescreen signalling word carried on 525-line video and sends it out one bit at a time. Software-style writes set three field registers: a 2-bit aspect-ratio code, a 4-bit header code and an 8-bit copy-control code. A start strobe freezes those values into a 14-bit data word and presets a 6-bit CRC (polynomial x^6 + x + 1, seeded with all ones). The block then shifts the frame out, lowest bit first, advancing one bit on each bit-clock enable.

The 14 data bits go out first. The CRC is accumulated while they pass, and its six bits follow. A one-cycle done pulse marks the end of the frame. Line timing, the analog waveform and any bus wrapper are supplied by the surrounding video path. Field registers may be rewritten at any time. A new value only reaches the line at the next accepted start.

Top module: `wss_frame_gen`

## Requirements
- R1: After reset, `ser_out`, `bit_valid` and `done` are low and all three field registers hold zero, so a frame started with no prior write carries fourteen zero data bits.
- R2: A write with `wr_addr` = 0 loads `wr_data[1:0]` into the aspect field, with 1 loads `wr_data[3:0]` into the header field, and with 2 loads `wr_data[7:0]` into the copy-control field. A write with address 3 changes nothing. In the frame, bits 1:0 carry aspect, bits 5:2 header and bits 13:6 copy control. The header values 0000 (copy-control data present) and 1111 (default) pass unchanged.
- R3: Frame bit n is the n-th bit on `ser_out`, so bit 0 is sent first and bit 13 is the last data bit.
- R4: Bits 19:14 hold a CRC over frame bits 0..13, taken in send order, with generator x^6 + x + 1 and every register bit preset to one. The first CRC bit produced (the highest-degree remainder term) is frame bit 14 and is sent right after bit 13.
- R5: While a frame is active, `bit_valid` is high exactly in the cycles where `bit_en` is high. The bit on `ser_out` is consumed in that cycle, and without `bit_en` the frame does not advance.
- R6: `done` rises for exactly one cycle, in the cycle after the one in which bit 19 was consumed. `bit_valid` is high exactly 20 times per frame.
- R7: A start strobe during an active frame is ignored. The frame in flight continues unchanged.
- R8: Field writes during an active frame do not alter that frame. They appear in the next frame started.
- R9: `ser_out` is low whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 2 | Field select: 0 aspect, 1 header, 2 copy control, 3 none |
| wr_data | input | 8 | Write data, low bits used for narrower fields |
| start | input | 1 | Begin a frame when idle |
| bit_en | input | 1 | Bit-clock enable, consumes one bit per high cycle |
| ser_out | output | 1 | Serial frame bit, LSB first |
| bit_valid | output | 1 | High when the bit on `ser_out` is consumed |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The hardest case to reach from the ports is a frame in flight that receives a second start strobe and a field write in the same cycle, while `bit_en` is stalling irregularly. This has to be shown to disturb neither the bits still to come nor the CRC. The stimulus injects exactly that combination partway through chosen frames, then starts the following frame without further writes so that the deferred value can be seen. Random field values, together with enable gaps drawn at random, walk the CRC through many remainders. Each one is compared against an independent polynomial long division.

// File: rtl/wss_pkg.sv
package wss_pkg;
   localparam int ASP_W   = 2;
   localparam int HDR_W   = 4;
   localparam int CC_W    = 8;
   localparam int CRC_W   = 6;
   localparam int DATA_W  = ASP_W + HDR_W + CC_W;
   localparam int FRAME_W = DATA_W + CRC_W;
   localparam int WDATA_W = CC_W;
   localparam int SEL_W   = 2;

   // generator x^6 + x + 1 : taps on x^1 and x^0
   localparam logic [CRC_W-1:0] CRC_POLY = 6'b000011;
   localparam logic [CRC_W-1:0] CRC_SEED = '1;

   typedef enum logic [SEL_W-1:0] {
      FLD_ASPECT = 2'd0,
      FLD_HEADER = 2'd1,
      FLD_COPY   = 2'd2,
      FLD_NONE   = 2'd3
   } fld_sel_e;
endpackage

// File: rtl/wss_field_regs.sv
module wss_field_regs
   import wss_pkg::*;
#(
   parameter int AW = ASP_W,
   parameter int HW = HDR_W,
   parameter int CW = CC_W,
   parameter int DW = WDATA_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SEL_W-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [AW-1:0] asp_q,
   output logic [HW-1:0] hdr_q,
   output logic [CW-1:0] cc_q
);
   if (DW < AW || DW < HW || DW < CW) begin : g_bad_width
      $error("write data narrower than a field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         asp_q <= '0;
         hdr_q <= '0;
         cc_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            FLD_ASPECT: asp_q <= wr_data[AW-1:0];
            FLD_HEADER: hdr_q <= wr_data[HW-1:0];
            FLD_COPY:   cc_q  <= wr_data[CW-1:0];
            default:    ;
         endcase
      end
   end

   AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({asp_q, hdr_q, cc_q})); // R8

   AST_SPARE_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == FLD_NONE) |=> $stable({asp_q, hdr_q, cc_q})); // R2
endmodule

// File: rtl/wss_crc_serial.sv
module wss_crc_serial #(
   parameter int              W    = 6,
   parameter logic [W-1:0]    POLY = 6'b000011,
   parameter logic [W-1:0]    SEED = '1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic preset,
   input  logic feed,
   input  logic drain,
   input  logic din,
   output logic msb
);
   if (W < 2) begin : g_bad_w
      $error("crc width too small");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("generator must have a constant term");
   end

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_fed;
   logic         fb;

   assign fb = din ^ crc_q[W-1];

   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign crc_fed[i] = POLY[i] & fb;
      end else begin : g_upper
         assign crc_fed[i] = crc_q[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       crc_q <= '0;
      else if (preset)  crc_q <= SEED;
      else if (feed)    crc_q <= crc_fed;
      else if (drain)   crc_q <= {crc_q[W-2:0], 1'b0};
   end

   assign msb = crc_q[W-1];

   AST_CRC_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(preset || feed || drain) |=> $stable(crc_q)); // R4

   AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> (crc_q == SEED)); // R4
endmodule

// File: rtl/wss_serializer.sv
module wss_serializer #(
   parameter int DATA_W = 14,
   parameter int CRC_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bit_en,
   input  logic [DATA_W-1:0] data_in,
   input  logic              crc_msb,
   output logic              crc_preset,
   output logic              crc_feed,
   output logic              crc_drain,
   output logic              crc_din,
   output logic              ser_out,
   output logic              bit_valid,
   output logic              done
);
   localparam int FRAME_W = DATA_W + CRC_W;
   localparam int IDX_W   = $clog2(FRAME_W + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
   localparam logic [IDX_W-1:0] DATA_END = IDX_W'(DATA_W);

   logic              busy;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] sh;
   logic              done_q;
   logic              accept, step, in_data, last;

   assign accept  = start && !busy;
   assign step    = busy && bit_en;
   assign in_data = idx < DATA_END;
   assign last    = idx == LAST_IDX;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         sh     <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
            sh   <= data_in;
         end else if (step) begin
            if (in_data) sh <= sh >> 1;
            if (last) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign crc_preset = accept;
   assign crc_feed   = step && in_data;
   assign crc_drain  = step && !in_data;
   assign crc_din    = sh[0];
   assign ser_out    = busy && (in_data ? sh[0] : crc_msb);
   assign bit_valid  = step;
   assign done       = done_q;

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_en) |=> ($stable(idx) && $stable(sh) && busy)); // R5

   AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && bit_en && !last) |=> (busy && idx == $past(idx) + 1'b1)); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> (done && !busy)); // R6

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= LAST_IDX)); // R6
endmodule

// File: rtl/wss_frame_gen.sv
module wss_frame_gen
   import wss_pkg::*;
#(
   parameter int AW = ASP_W,
   parameter int HW = HDR_W,
   parameter int CW = CC_W,
   parameter int RW = CRC_W,
   parameter logic [RW-1:0] POLY = CRC_POLY,
   parameter logic [RW-1:0] SEED = CRC_SEED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_addr,
   input  logic [WDATA_W-1:0] wr_data,
   input  logic             start,
   input  logic             bit_en,
   output logic             ser_out,
   output logic             bit_valid,
   output logic             done
);
   localparam int DW = AW + HW + CW;

   logic [AW-1:0] asp_q;
   logic [HW-1:0] hdr_q;
   logic [CW-1:0] cc_q;
   logic          crc_preset, crc_feed, crc_drain, crc_din, crc_msb;

   wss_field_regs #(.AW(AW), .HW(HW), .CW(CW), .DW(WDATA_W)) u_fields (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .asp_q   (asp_q),
      .hdr_q   (hdr_q),
      .cc_q    (cc_q)
   );

   wss_crc_serial #(.W(RW), .POLY(POLY), .SEED(SEED)) u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .preset (crc_preset),
      .feed   (crc_feed),
      .drain  (crc_drain),
      .din    (crc_din),
      .msb    (crc_msb)
   );

   wss_serializer #(.DATA_W(DW), .CRC_W(RW)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .bit_en     (bit_en),
      .data_in    ({cc_q, hdr_q, asp_q}),
      .crc_msb    (crc_msb),
      .crc_preset (crc_preset),
      .crc_feed   (crc_feed),
      .crc_drain  (crc_drain),
      .crc_din    (crc_din),
      .ser_out    (ser_out),
      .bit_valid  (bit_valid),
      .done       (done)
   );

   AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> bit_en); // R5

   AST_NO_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !bit_valid); // R6
endmodule

// File: tb/sim_wss_frame_gen.sv
module sim_wss_frame_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, start, bit_en;
   logic [1:0] wr_addr;
   logic [7:0] wr_data;
   logic       ser_out, bit_valid, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // behavioural reference state
   logic [1:0]  m_asp;
   logic [3:0]  m_hdr;
   logic [7:0]  m_cc;
   logic [19:0] m_frame;
   logic [19:0] rx;
   bit          m_busy, m_done;
   int          m_idx;
   string       cur_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   wss_frame_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .bit_en(bit_en),
      .ser_out(ser_out), .bit_valid(bit_valid), .done(done)
   );

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // frame by polynomial long division, first sent bit = highest degree
   function automatic logic [19:0] build(input logic [1:0] a, input logic [3:0] h, input logic [7:0] c);
      logic [13:0] d;
      logic [19:0] v;
      logic [19:0] fr;
      d = {c, h, a};
      v = '0;
      for (int k = 0; k < 14; k++) v[19-k] = d[k];
      v[19:14] = v[19:14] ^ 6'h3F;
      for (int i = 19; i >= 6; i--)
         if (v[i]) v[i -: 7] = v[i -: 7] ^ 7'b1000011;
      fr = '0;
      fr[13:0] = d;
      for (int j = 0; j < 6; j++) fr[14+j] = v[5-j];
      return fr;
   endfunction

   task automatic step(input logic s, input logic be, input logic we,
                       input logic [1:0] wa, input logic [7:0] wd);
      logic exp_valid, exp_ser;
      start = s; bit_en = be; wr_en = we; wr_addr = wa; wr_data = wd;
      #1;
      exp_valid = m_busy && be;
      exp_ser   = m_busy ? m_frame[m_idx] : 1'b0;
      check("R5", 20'(bit_valid), 20'(exp_valid));
      if (!m_busy)        check("R9", 20'(ser_out), 20'(exp_ser));
      else if (m_idx < 14) check("R3", 20'(ser_out), 20'(exp_ser));
      else                check("R4", 20'(ser_out), 20'(exp_ser));
      check("R6", 20'(done), 20'(m_done));
      if (exp_valid) rx[m_idx] = ser_out;
      if (m_done) check(cur_tag, rx, m_frame);
      @(posedge clk);
      if (s && !m_busy) begin
         m_frame = build(m_asp, m_hdr, m_cc);
         m_busy = 1; m_idx = 0; m_done = 0; rx = '0;
      end else if (m_busy && be) begin
         if (m_idx == 19) begin m_busy = 0; m_done = 1; end
         else begin m_idx++; m_done = 0; end
      end else begin
         m_done = 0;
      end
      if (we) begin
         case (wa)
            2'd0: m_asp = wd[1:0];
            2'd1: m_hdr = wd[3:0];
            2'd2: m_cc  = wd;
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      step(0, 0, 1, a, d);
   endtask

   task automatic run_frame(input string tag, input int gap, input bit poke);
      bit poked = 0;
      logic be;
      cur_tag = tag;
      step(1, 0, 0, 2'd0, 8'd0);
      while (m_busy) begin
         be = (gap == 0) ? 1'b1 : ($urandom_range(gap) == 0);
         if (poke && !poked && m_idx == 7) begin
            // R7 restart and R8 write in the same mid-frame cycle
            step(1, be, 1, 2'($urandom_range(2)), 8'($urandom));
            poked = 1;
         end else begin
            step(0, be, 0, 2'd0, 8'd0);
         end
      end
      step(0, 0, 0, 2'd0, 8'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_asp = 0; m_hdr = 0; m_cc = 0; m_frame = 0; rx = 0;
      m_busy = 0; m_done = 0; m_idx = 0;
      rst_n = 0; start = 0; bit_en = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
      repeat (3) @(negedge clk);
      // R1 outputs quiet during reset
      check("R1", {17'd0, ser_out, bit_valid, done}, 20'd0);
      rst_n = 1;
      @(negedge clk);
      check("R1", {17'd0, ser_out, bit_valid, done}, 20'd0);

      run_frame("R1", 0, 0);                  // zero fields after reset

      wr(2'd0, 8'h01); wr(2'd1, 8'h0F); wr(2'd2, 8'h03);
      run_frame("R2", 0, 0);
      wr(2'd3, 8'hFF);                        // R2 spare address ignored
      run_frame("R2", 0, 0);

      wr(2'd0, 8'h02); wr(2'd1, 8'h00); wr(2'd2, 8'h10);
      run_frame("R3", 0, 0);

      run_frame("R5", 3, 0);                  // stalled bit enables
      run_frame("R7", 1, 1);                  // restart and write mid-frame
      run_frame("R8", 0, 0);                  // deferred write now visible

      for (int n = 0; n < 40; n++) begin
         wr(2'd0, 8'($urandom));
         wr(2'd1, 8'($urandom));
         wr(2'd2, 8'($urandom));
         run_frame("R4", n % 3, (n % 4) == 0);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule